// File: doc/BRIEF.md
# Lane Code-Group Sync Receiver

This block is the receive-side controller that brings one serial converter lane out of code-group synchronisation. It sits after the 8b/10b decoder. For each symbol it takes the decoded byte, a flag that marks a control character, and two error flags, one for decoding and one for running disparity. It drives the active-low synchronisation request line back to the transmitter. While that line is low, the transmitter sends the comma control character (K28.5, byte 0xBC) on every symbol.

After reset, or after a resynchronisation request, the block holds the request line low and counts consecutive good commas. When the run reaches a parameterised length (four by default), the block releases the line high. The link then leaves the code-group phase and goes straight into initial lane alignment. A sticky flag reports that the code-group phase is complete, and a one-cycle strobe marks the symbol on which the line was released. Any bad symbol during the code-group phase restarts the count from zero.

The symbol input is a stream qualified by `sym_valid` and has no back-pressure. The block has no ready output. Every cycle with `sym_valid` high consumes exactly one symbol, and cycles with `sym_valid` low carry no symbol.

Top module: `cgs_sync_rx`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `sync_n` is 0, `cgs_done` is 0 and `sync_release` is 0.
- R2: An accepted symbol counts as a good comma only if `sym_is_ctrl`=1, `sym_data`=0xBC, `sym_dec_err`=0 and `sym_disp_err`=0. A data byte 0xBC, another control character, or any error flag does not count.
- R3: `sync_n` goes high in the cycle after the clock edge that accepts the COMMA_RUN-th consecutive good comma (default 4). With fewer consecutive good commas it stays low.
- R4: During the code-group phase, any accepted symbol that is not a good comma clears the run to zero, so a full new run of COMMA_RUN good commas is then needed.
- R5: A cycle with `sym_valid`=0 neither extends nor breaks the run.
- R6: `sync_release` is high for exactly one cycle, and that cycle is the first cycle in which `sync_n` is high.
- R7: `cgs_done` rises together with `sync_n` and stays high until reset or a resync request.
- R8: Once released, `sync_n` stays high whatever symbols arrive, including bad ones, until reset or a resync request.
- R9: `resync_req` sampled high returns the block to the code-group phase. In the next cycle `sync_n`=0 and `cgs_done`=0, and the run restarts from zero. A resync has priority over a symbol accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resync_req | input | 1 | Request to restart code-group synchronisation |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_data | input | 8 | Decoded byte |
| sym_is_ctrl | input | 1 | Symbol is a control character |
| sym_dec_err | input | 1 | Symbol failed 10b-to-8b decoding |
| sym_disp_err | input | 1 | Running-disparity error on this symbol |
| sync_n | output | 1 | Active-low synchronisation request to the transmitter |
| cgs_done | output | 1 | Sticky: code-group phase completed |
| sync_release | output | 1 | One-cycle strobe on the release of `sync_n` |

## Verification
Every result is registered once. The effect of a symbol or a resync sampled at clock edge k shows up on `sync_n`, `cgs_done` and `sync_release` right after edge k. The bench therefore drives each stimulus on a falling edge, advances one rising edge, and compares all three outputs on the next falling edge against a reference model updated for that same edge. Directed runs cover runs broken at every length, gaps, look-alike symbols and a resync colliding with a symbol. Seeded random traffic then mixes these cases.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [0:0] {
    PH_CODE_GROUP = 1'b0,
    PH_ALIGN      = 1'b1
  } link_phase_e;

  typedef struct packed {
    logic       valid;
    logic [7:0] data;
    logic       is_ctrl;
    logic       dec_err;
    logic       disp_err;
  } rx_sym_t;
endpackage

// File: rtl/cgs_sym_classify.sv
module cgs_sym_classify
  import cgs_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  COMMA_BYTE = 8'hBC
) (
  input  rx_sym_t sym,
  output logic    good_comma,
  output logic    bad_symbol
);
  logic byte_match;
  logic clean;

  always_comb begin
    byte_match = (sym.data[DATA_W-1:0] == COMMA_BYTE[DATA_W-1:0]);
    clean      = !sym.dec_err && !sym.disp_err;
    // R2: all four qualifiers needed
    good_comma = sym.valid && sym.is_ctrl && byte_match && clean;
    bad_symbol = sym.valid && !good_comma;
  end
endmodule

// File: rtl/cgs_run_counter.sv
module cgs_run_counter #(
  parameter int COMMA_RUN = 4,
  parameter int CNT_W     = $clog2(COMMA_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             run_hit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMA_RUN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assign run_hit = inc && (count == LAST);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count < CNT_W'(COMMA_RUN))
    else $error("run counter exceeded run length");
endmodule

// File: rtl/cgs_link_fsm.sv
module cgs_link_fsm
  import cgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic resync,
  input  logic run_hit,
  output logic in_code_group,
  output logic sync_n,
  output logic done,
  output logic release_strobe
);
  link_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (resync)                                  phase_d = PH_CODE_GROUP;
    else if (phase_q == PH_CODE_GROUP && run_hit) phase_d = PH_ALIGN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q        <= PH_CODE_GROUP;
      sync_n         <= 1'b0;
      done           <= 1'b0;
      release_strobe <= 1'b0;
    end else begin
      phase_q        <= phase_d;
      sync_n         <= (phase_d == PH_ALIGN);
      release_strobe <= (phase_q == PH_CODE_GROUP) && (phase_d == PH_ALIGN);
      if (resync)       done <= 1'b0;
      else if (run_hit) done <= 1'b1;
    end
  end

  assign in_code_group = (phase_q == PH_CODE_GROUP);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_strobe |=> !release_strobe)
    else $error("release strobe longer than one cycle");

  p_strobe_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_strobe |-> sync_n)
    else $error("release strobe without released line");

  p_hold_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && !resync) |=> sync_n)
    else $error("line dropped without resync");

  p_resync_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (!sync_n && !done))
    else $error("resync did not restart code-group phase");

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !resync) |=> done)
    else $error("done flag not sticky");
endmodule

// File: rtl/cgs_sync_rx.sv
module cgs_sync_rx
  import cgs_pkg::*;
#(
  parameter int         COMMA_RUN  = 4,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] COMMA_BYTE = 8'hBC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync_req,
  input  logic              sym_valid,
  input  logic [DATA_W-1:0] sym_data,
  input  logic              sym_is_ctrl,
  input  logic              sym_dec_err,
  input  logic              sym_disp_err,
  output logic              sync_n,
  output logic              cgs_done,
  output logic              sync_release
);
  localparam int CNT_W = $clog2(COMMA_RUN + 1);

  rx_sym_t          sym;
  logic             good_comma;
  logic             bad_symbol;
  logic             in_cg;
  logic             run_clear;
  logic             run_inc;
  logic             run_hit;
  logic [CNT_W-1:0] run_cnt;

  always_comb begin
    sym          = '0;
    sym.valid    = sym_valid;
    sym.data     = 8'(sym_data);
    sym.is_ctrl  = sym_is_ctrl;
    sym.dec_err  = sym_dec_err;
    sym.disp_err = sym_disp_err;
  end

  cgs_sym_classify #(.DATA_W(DATA_W), .COMMA_BYTE(COMMA_BYTE)) u_classify (
    .sym        (sym),
    .good_comma (good_comma),
    .bad_symbol (bad_symbol)
  );

  assign run_inc   = in_cg && good_comma && !resync_req;
  assign run_clear = resync_req || !in_cg || bad_symbol || run_hit;

  cgs_run_counter #(.COMMA_RUN(COMMA_RUN), .CNT_W(CNT_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (run_clear),
    .inc     (run_inc),
    .count   (run_cnt),
    .run_hit (run_hit)
  );

  cgs_link_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .resync         (resync_req),
    .run_hit        (run_hit),
    .in_code_group  (in_cg),
    .sync_n         (sync_n),
    .done           (cgs_done),
    .release_strobe (sync_release)
  );

  p_bad_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cg && sym_valid && !sym_is_ctrl) |=> (run_cnt == '0))
    else $error("bad symbol did not clear run");

  p_gap_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cg && !sym_valid && !resync_req) |=> $stable(run_cnt))
    else $error("idle cycle altered run");

  p_done_with_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> cgs_done)
    else $error("done flag not raised with line release");
endmodule

// File: tb/cgs_sync_rx_tb.sv
module cgs_sync_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       resync_req;
  logic       sym_valid;
  logic [7:0] sym_data;
  logic       sym_is_ctrl;
  logic       sym_dec_err;
  logic       sym_disp_err;
  logic       sync_n;
  logic       cgs_done;
  logic       sync_release;

  int n_checks = 0;
  int n_fails  = 0;
  int m_cnt    = 0;
  bit m_sync   = 0;
  bit m_done   = 0;
  bit m_pulse  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cgs_sync_rx u_dut (
    .clk(clk), .rst_n(rst_n), .resync_req(resync_req), .sym_valid(sym_valid),
    .sym_data(sym_data), .sym_is_ctrl(sym_is_ctrl), .sym_dec_err(sym_dec_err),
    .sym_disp_err(sym_disp_err), .sync_n(sync_n), .cgs_done(cgs_done),
    .sync_release(sync_release)
  );

  function automatic bit is_good(bit v, logic [7:0] d, bit k, bit de, bit pe);
    return v && k && (d == 8'hBC) && !de && !pe;
  endfunction

  task automatic check(string tag);
    n_checks++;
    if ({~sync_n, cgs_done, sync_release} !== {~m_sync, m_done, m_pulse}) begin
      n_fails++;
      $display("FAIL %s: sync_n/done/release got %b%b%b exp %b%b%b", tag,
               sync_n, cgs_done, sync_release, m_sync, m_done, m_pulse);
    end
  endtask

  task automatic step(bit v, logic [7:0] d, bit k, bit de, bit pe, bit rs, string tag);
    sym_valid = v; sym_data = d; sym_is_ctrl = k;
    sym_dec_err = de; sym_disp_err = pe; resync_req = rs;
    @(posedge clk);
    m_pulse = 0;
    if (rs) begin
      m_sync = 0; m_done = 0; m_cnt = 0;
    end else if (!m_sync && v) begin
      if (is_good(v, d, k, de, pe)) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_sync = 1; m_done = 1; m_pulse = 1; m_cnt = 0;
        end
      end else m_cnt = 0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic comma(string tag);
    step(1, 8'hBC, 1, 0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; resync_req = 0; sym_valid = 0; sym_data = 0;
    sym_is_ctrl = 0; sym_dec_err = 0; sym_disp_err = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    step(0, 8'h00, 0, 0, 0, 0, "R1 after reset");

    // R3: three commas do not release, the fourth does (R6, R7)
    comma("R3 c1"); comma("R3 c2"); comma("R3 c3");
    comma("R3 R6 R7 fourth releases");
    // R8: bad symbols after release keep line high
    step(1, 8'h12, 0, 1, 1, 0, "R8 error after release");
    step(1, 8'hBC, 1, 0, 1, 0, "R8 disparity after release");
    // R9: resync
    step(0, 8'h00, 0, 0, 0, 1, "R9 resync");
    // R4: run broken at every length
    for (int len = 1; len < 4; len++) begin
      for (int i = 0; i < len; i++) comma("R4 partial run");
      step(1, 8'hBC, 1, 1, 0, 0, "R4 decode error breaks run");
    end
    comma("R4 a"); comma("R4 b"); comma("R4 c"); comma("R4 fourth after break");
    step(0, 8'h00, 0, 0, 0, 1, "R9 resync again");
    // R2: look-alikes
    comma("R2 a"); step(1, 8'hBC, 0, 0, 0, 0, "R2 data 0xBC");
    comma("R2 b"); comma("R2 c"); comma("R2 d");
    step(1, 8'h1C, 1, 0, 0, 0, "R2 other control char");
    comma("R2 e"); comma("R2 f"); comma("R2 g");
    step(1, 8'hBC, 1, 0, 1, 0, "R2 disparity error");
    // R5: gaps
    comma("R5 a"); step(0, 8'hBC, 1, 0, 0, 0, "R5 gap");
    comma("R5 b"); step(0, 8'h00, 0, 1, 1, 0, "R5 gap with flags");
    comma("R5 c"); comma("R5 fourth across gaps");
    // R9: resync colliding with symbols
    step(1, 8'hBC, 1, 0, 0, 1, "R9 resync with comma");
    comma("R9 a"); comma("R9 b"); comma("R9 c");
    step(1, 8'hBC, 1, 0, 0, 1, "R9 resync beats fourth comma");
    comma("R9 d"); comma("R9 e"); comma("R9 f"); comma("R9 release after restart");

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit v, k, de, pe, rs;
      logic [7:0] d;
      r  = int'($urandom_range(0, 99));
      v  = (r < 85);
      rs = ($urandom_range(0, 99) < 2);
      d  = ($urandom_range(0, 9) < 8) ? 8'hBC : 8'($urandom);
      k  = ($urandom_range(0, 9) < 9);
      de = ($urandom_range(0, 19) == 0);
      pe = ($urandom_range(0, 19) == 0);
      step(v, d, k, de, pe, rs, "R3 random");
    end

    // R1: reset mid-link
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    m_sync = 0; m_done = 0; m_pulse = 0; m_cnt = 0;
    check("R1 reset mid-run");
    rst_n = 1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule